// File: doc/BRIEF.md
# Text Display Raster Timing Generator

This block produces the complete raster timing for a character display of 25 rows by 40 columns. It is advanced by a clock enable that pulses once per character period (1 µs, so 64 periods make one 64 µs line). It keeps a horizontal position and a frame line number, and from these it derives a composite sync, an odd/even field flag and the active-text window. While the window is open it also reports which character row, character column and scan line inside the character cell is being painted. Downstream logic uses these values to look up glyphs and generate pixels.

A two-bit field-structure select chooses true interlace (two fields of 312.5 lines), alternating fields of 312 and 313 lines, fixed 312-line fields, or an external-sync setting in which the internal sync output stays quiet. A two-bit double-height code can stretch either the upper half (rows 0–11) or the lower half (rows 12–23) of the page over the full main area, each cell line then being shown twice. The status row (row 24) can be placed either above or below the 24 main rows.

Text occupies 250 lines of each field, starting at field line 42. Each character row is 10 scan lines tall. On each line the window covers character periods 17 to 56.

Top module: `txt_raster_gen`

## Requirements
- R1: `h_count` counts 0..63 and advances by one only on clocks where `tick_en` is 1. It wraps from 63 to 0, and that wrap ends the line.
- R2: `v_count` is the frame line number, starting at 1. It advances when a line ends and returns to 1 after line 625 when `field_mode` is 00 or 01, and after line 624 when `field_mode` is 10 or 11.
- R3: With `field_mode` 00 the second field begins half-way through line 313, at `h_count` 32. With any other mode the second field begins at the start of line 313. Field-relative line numbers count 1.. from the start of the first field. In the second field they count 0 for the half line that opens it under mode 00, and 1 for line 313 under the other modes.
- R4: `field_o` is 1 throughout the second field and 0 throughout the first, so it toggles once per field. While `oe_force_low` is 1 it is held at 0.
- R5: `sync_o` is the exclusive-OR of a line pulse (`h_count` < 5) and a vertical window. The window lasts the first five half-lines of each field, counted in half-lines from the field start defined in R3.
- R6: With `field_mode` 11, `sync_o` is always 0. Line, field and text timing then follow the fixed 312-line structure.
- R7: `text_active` is 1 exactly when the field-relative line is in 42..291 and `h_count` is in 17..56.
- R8: Inside the window, `char_col` = `h_count` − 17 (0..39). With the status row last and no double height, text line t = relative line − 42 shows row t/10 and cell line t mod 10.
- R9: With `status_first` 0, the 25th band of 10 lines shows row 24. With `status_first` 1, the first band shows row 24 and the following 24 bands show rows 0..23 in order.
- R10: `dh_mode` bit 0 = 0 means normal height. `dh_mode` 01 shows rows 0..11 and `dh_mode` 11 shows rows 12..23, each row over two bands of the main area. The cell line reported is (band parity × 10 + scan) / 2. The status row is never stretched.
- R11: Outside the window, `char_col`, `char_row` and `cell_line` are 0.
- R12: During reset `h_count` is 0, `v_count` is 1, and `field_o`, `sync_o` and `text_active` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | One pulse per character period |
| field_mode | input | 2 | 00 interlace, 01 alternating 312/313, 10 fixed 312, 11 external sync |
| dh_mode | input | 2 | Double-height code: x0 normal, 01 upper half, 11 lower half |
| status_first | input | 1 | 1 puts the status row above the main rows |
| oe_force_low | input | 1 | Holds the odd/even flag at 0 |
| h_count | output | 6 | Character period within the line |
| v_count | output | 10 | Frame line number, starting at 1 |
| sync_o | output | 1 | Composite sync |
| field_o | output | 1 | Odd/even field flag |
| text_active | output | 1 | Active-text window |
| char_col | output | 6 | Character column |
| char_row | output | 5 | Character row |
| cell_line | output | 4 | Scan line within the character cell |

## Verification
In interlace mode the field flag flips and the vertical window opens in the same tick: the midpoint of line 313. In that tick the line pulse is absent, so `sync_o` goes high mid-line. The bench runs a whole interlaced frame tick by tick and compares `field_o` and `sync_o` at every tick against a model built on half-line counting, so an early or late flip at that midpoint shows up. A second coincidence is the last tick of a text line that is also the last line of a character band. In that tick the cell-line counter wraps and the band advances together. The double-height and status-first runs judge it by the row and cell-line values reported on the next line.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
    typedef enum logic [1:0] {
        FM_INTERLACE = 2'b00,
        FM_ALTERNATE = 2'b01,
        FM_FIXED     = 2'b10,
        FM_EXTERNAL  = 2'b11
    } field_mode_e;
endpackage

// File: rtl/rtg_hcount.sv
module rtg_hcount #(
    parameter int LINE_TICKS = 64,
    parameter int SYNC_TICKS = 5,
    parameter int TEXT_START = 17,
    parameter int TEXT_COLS  = 40,
    parameter int HW         = 6,
    parameter int CW         = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_en,
    output logic [HW-1:0] h_cnt,
    output logic          line_end,
    output logic          hsync,
    output logic          second_half,
    output logic          in_cols,
    output logic [CW-1:0] col
);
    localparam logic [HW-1:0] H_LAST = HW'(LINE_TICKS - 1);
    localparam logic [HW-1:0] H_SYNC = HW'(SYNC_TICKS);
    localparam logic [HW-1:0] H_HALF = HW'(LINE_TICKS / 2);
    localparam logic [HW-1:0] H_TXT0 = HW'(TEXT_START);
    localparam logic [HW-1:0] H_TXTE = HW'(TEXT_START + TEXT_COLS);

    typedef struct packed {
        logic [HW-1:0] h;
    } hstate_t;

    hstate_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick_en) begin
            st_d.h = (st_q.h == H_LAST) ? '0 : st_q.h + HW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign h_cnt       = st_q.h;
    assign line_end    = tick_en && (st_q.h == H_LAST);
    assign hsync       = st_q.h < H_SYNC;
    assign second_half = st_q.h >= H_HALF;
    assign in_cols     = (st_q.h >= H_TXT0) && (st_q.h < H_TXTE);
    assign col         = CW'(st_q.h - H_TXT0);
endmodule

// File: rtl/rtg_vcount.sv
module rtg_vcount
    import rtg_pkg::*;
#(
    parameter int FIELD_LINES = 312,
    parameter int VS_HALVES   = 5,
    parameter int LW          = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_end,
    input  logic          second_half,
    input  field_mode_e   mode,
    output logic [LW-1:0] line_cnt,
    output logic [LW-1:0] rel_line,
    output logic          field1,
    output logic          vsync
);
    localparam int XW = LW + 1;
    localparam logic [LW-1:0] L_ONE    = LW'(1);
    localparam logic [LW-1:0] L_FIELD  = LW'(FIELD_LINES);
    localparam logic [LW-1:0] L_FIELD1 = LW'(FIELD_LINES + 1);
    localparam logic [LW-1:0] L_LONG   = LW'(2 * FIELD_LINES + 1);
    localparam logic [LW-1:0] L_SHORT  = LW'(2 * FIELD_LINES);
    localparam logic [XW-1:0] X_LONG   = XW'(2 * FIELD_LINES + 1);
    localparam logic [XW-1:0] X_SHORT  = XW'(2 * FIELD_LINES);
    localparam logic [XW-1:0] X_VS     = XW'(VS_HALVES);

    typedef struct packed {
        logic [LW-1:0] line;
    } vstate_t;

    vstate_t st_d, st_q;

    logic          interlace;
    logic          long_frame;
    logic [XW-1:0] half_idx;
    logic [XW-1:0] rel_half;

    assign interlace  = (mode == FM_INTERLACE);
    assign long_frame = (mode == FM_INTERLACE) || (mode == FM_ALTERNATE);

    always_comb begin
        st_d = st_q;
        if (line_end) begin
            st_d.line = (st_q.line >= (long_frame ? L_LONG : L_SHORT)) ? L_ONE
                                                                        : st_q.line + L_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{line: L_ONE};
        else        st_q <= st_d;
    end

    // Position in half-lines from the start of the frame.
    assign half_idx = {st_q.line - L_ONE, second_half};
    assign field1   = interlace ? (half_idx >= X_LONG) : (st_q.line > L_FIELD);
    assign rel_half = field1 ? half_idx - (interlace ? X_LONG : X_SHORT) : half_idx;
    assign vsync    = rel_half < X_VS;
    assign rel_line = field1 ? st_q.line - (interlace ? L_FIELD1 : L_FIELD) : st_q.line;
    assign line_cnt = st_q.line;
endmodule

// File: rtl/rtg_rowmap.sv
module rtg_rowmap #(
    parameter int ROWS       = 25,
    parameter int CELL_LINES = 10,
    parameter int FIRST_LINE = 42,
    parameter int LW         = 10,
    parameter int RW         = 5,
    parameter int SW         = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_end,
    input  logic [LW-1:0] rel_line,
    input  logic          in_cols,
    input  logic          status_first,
    input  logic [1:0]    dh_mode,
    output logic          active,
    output logic [RW-1:0] row,
    output logic [SW-1:0] scan
);
    localparam int KW        = SW + 1;
    localparam int LAST_LINE = FIRST_LINE + ROWS * CELL_LINES - 1;
    localparam logic [LW-1:0] R_FIRST   = LW'(FIRST_LINE);
    localparam logic [LW-1:0] R_LAST    = LW'(LAST_LINE);
    localparam logic [SW-1:0] S_LAST    = SW'(CELL_LINES - 1);
    localparam logic [RW-1:0] STAT_ROW  = RW'(ROWS - 1);
    localparam logic [RW-1:0] HALF_ROWS = RW'((ROWS - 1) / 2);
    localparam logic [KW-1:0] K_CELL    = KW'(CELL_LINES);

    typedef struct packed {
        logic [SW-1:0] scan;
        logic [RW-1:0] band;
    } rstate_t;

    rstate_t st_d, st_q;

    logic          text_line;
    logic          is_status;
    logic [RW-1:0] main_idx;
    logic [KW-1:0] stretched;
    logic [RW-1:0] row_raw;
    logic [SW-1:0] scan_raw;

    assign text_line = (rel_line >= R_FIRST) && (rel_line <= R_LAST);

    always_comb begin
        st_d = st_q;
        if (line_end) begin
            if (!text_line) begin
                st_d = '0;
            end else if (st_q.scan == S_LAST) begin
                st_d.scan = '0;
                st_d.band = st_q.band + RW'(1);
            end else begin
                st_d.scan = st_q.scan + SW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        is_status = status_first ? (st_q.band == '0) : (st_q.band == STAT_ROW);
        main_idx  = status_first ? st_q.band - RW'(1) : st_q.band;
        stretched = main_idx[0] ? {1'b0, st_q.scan} + K_CELL : {1'b0, st_q.scan};
        if (is_status) begin
            row_raw  = STAT_ROW;
            scan_raw = st_q.scan;
        end else if (!dh_mode[0]) begin
            row_raw  = main_idx;
            scan_raw = st_q.scan;
        end else begin
            row_raw  = (dh_mode[1] ? HALF_ROWS : '0) + (main_idx >> 1);
            scan_raw = stretched[KW-1:1];
        end
    end

    assign active = text_line && in_cols;
    assign row    = active ? row_raw : '0;
    assign scan   = active ? scan_raw : '0;
endmodule

// File: rtl/txt_raster_gen.sv
module txt_raster_gen
    import rtg_pkg::*;
#(
    parameter int LINE_TICKS  = 64,
    parameter int SYNC_TICKS  = 5,
    parameter int TEXT_START  = 17,
    parameter int TEXT_COLS   = 40,
    parameter int FIELD_LINES = 312,
    parameter int VS_HALVES   = 5,
    parameter int FIRST_LINE  = 42,
    parameter int ROWS        = 25,
    parameter int CELL_LINES  = 10,
    localparam int HW = $clog2(LINE_TICKS),
    localparam int CW = $clog2(TEXT_COLS),
    localparam int LW = $clog2(2 * FIELD_LINES + 2),
    localparam int RW = $clog2(ROWS),
    localparam int SW = $clog2(CELL_LINES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_en,
    input  logic [1:0]    field_mode,
    input  logic [1:0]    dh_mode,
    input  logic          status_first,
    input  logic          oe_force_low,
    output logic [HW-1:0] h_count,
    output logic [LW-1:0] v_count,
    output logic          sync_o,
    output logic          field_o,
    output logic          text_active,
    output logic [CW-1:0] char_col,
    output logic [RW-1:0] char_row,
    output logic [SW-1:0] cell_line
);
    field_mode_e   mode;
    logic          line_end;
    logic          hsync;
    logic          second_half;
    logic          in_cols;
    logic [CW-1:0] col_raw;
    logic [LW-1:0] rel_line;
    logic          field1;
    logic          vsync;
    logic          active;

    assign mode = field_mode_e'(field_mode);

    rtg_hcount #(
        .LINE_TICKS(LINE_TICKS), .SYNC_TICKS(SYNC_TICKS), .TEXT_START(TEXT_START),
        .TEXT_COLS(TEXT_COLS), .HW(HW), .CW(CW)
    ) u_h (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .h_cnt(h_count),
        .line_end(line_end), .hsync(hsync), .second_half(second_half),
        .in_cols(in_cols), .col(col_raw)
    );

    rtg_vcount #(
        .FIELD_LINES(FIELD_LINES), .VS_HALVES(VS_HALVES), .LW(LW)
    ) u_v (
        .clk(clk), .rst_n(rst_n), .line_end(line_end), .second_half(second_half),
        .mode(mode), .line_cnt(v_count), .rel_line(rel_line), .field1(field1),
        .vsync(vsync)
    );

    rtg_rowmap #(
        .ROWS(ROWS), .CELL_LINES(CELL_LINES), .FIRST_LINE(FIRST_LINE),
        .LW(LW), .RW(RW), .SW(SW)
    ) u_r (
        .clk(clk), .rst_n(rst_n), .line_end(line_end), .rel_line(rel_line),
        .in_cols(in_cols), .status_first(status_first), .dh_mode(dh_mode),
        .active(active), .row(char_row), .scan(cell_line)
    );

    assign sync_o      = (mode == FM_EXTERNAL) ? 1'b0 : (hsync ^ vsync);
    assign field_o     = field1 && !oe_force_low;
    assign text_active = active;
    assign char_col    = active ? col_raw : '0;
endmodule

// File: rtl/txt_raster_gen_chk.sv
module txt_raster_gen_chk #(
    parameter int LINE_TICKS  = 64,
    parameter int TEXT_COLS   = 40,
    parameter int FIELD_LINES = 312,
    parameter int HW = 6,
    parameter int CW = 6,
    parameter int LW = 10,
    parameter int RW = 5,
    parameter int SW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick_en,
    input logic [1:0]    field_mode,
    input logic          oe_force_low,
    input logic [HW-1:0] h_count,
    input logic [LW-1:0] v_count,
    input logic          sync_o,
    input logic          field_o,
    input logic          text_active,
    input logic [CW-1:0] char_col,
    input logic [RW-1:0] char_row,
    input logic [SW-1:0] cell_line
);
    p_hwrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && h_count == HW'(LINE_TICKS - 1)) |=> (h_count == '0));

    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> ($stable(h_count) && $stable(v_count)));

    p_vrange_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (v_count != '0) && (v_count <= LW'(2 * FIELD_LINES + 1)));

    p_force_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        oe_force_low |-> !field_o);

    p_ext_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (field_mode == 2'b11) |-> !sync_o);

    p_col_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        text_active |-> (char_col < CW'(TEXT_COLS)));

    p_idle_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !text_active |-> (char_col == '0 && char_row == '0 && cell_line == '0));
endmodule

bind txt_raster_gen txt_raster_gen_chk #(
    .LINE_TICKS(LINE_TICKS), .TEXT_COLS(TEXT_COLS), .FIELD_LINES(FIELD_LINES),
    .HW(HW), .CW(CW), .LW(LW), .RW(RW), .SW(SW)
) u_chk (.*);

// File: tb/txt_raster_gen_test.sv
module txt_raster_gen_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 195000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic [1:0] field_mode = 2'b00;
    logic [1:0] dh_mode = 2'b00;
    logic       status_first = 1'b0;
    logic       oe_force_low = 1'b0;
    logic [5:0] h_count;
    logic [9:0] v_count;
    logic       sync_o, field_o, text_active;
    logic [5:0] char_col;
    logic [4:0] char_row;
    logic [3:0] cell_line;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    txt_raster_gen uut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .field_mode(field_mode),
        .dh_mode(dh_mode), .status_first(status_first), .oe_force_low(oe_force_low),
        .h_count(h_count), .v_count(v_count), .sync_o(sync_o), .field_o(field_o),
        .text_active(text_active), .char_col(char_col), .char_row(char_row),
        .cell_line(cell_line)
    );

    typedef struct packed {
        int h; int v; int fld; int sync; int act; int col; int row; int scan;
    } exp_t;

    // Expected outputs after n enabled ticks, from the requirements.
    function automatic exp_t model(int n, int mode, int sf, int dh, int fl);
        exp_t e;
        int flen, ln, hidx, f1, rel, rh, t, slot, sc, m;
        flen  = (mode < 2) ? 625 : 624;
        e.h   = n % 64;
        ln    = (n / 64) % flen + 1;
        e.v   = ln;
        hidx  = 2 * (ln - 1) + ((e.h >= 32) ? 1 : 0);
        f1    = (mode == 0) ? int'(hidx >= 625) : int'(ln >= 313);
        rel   = (f1 == 0) ? ln : ((mode == 0) ? ln - 313 : ln - 312);
        rh    = (f1 == 0) ? hidx : hidx - ((mode == 0) ? 625 : 624);
        e.sync = (mode == 3) ? 0 : (int'(e.h < 5) ^ int'(rh < 5));
        e.fld = (f1 != 0 && fl == 0) ? 1 : 0;
        e.act = (rel >= 42 && rel <= 291 && e.h >= 17 && e.h <= 56) ? 1 : 0;
        e.col = 0; e.row = 0; e.scan = 0;
        if (e.act != 0) begin
            t = rel - 42; slot = t / 10; sc = t % 10;
            e.col = e.h - 17;
            if ((sf != 0 && slot == 0) || (sf == 0 && slot == 24)) begin
                e.row = 24; e.scan = sc;
            end else begin
                m = (sf != 0) ? slot - 1 : slot;
                if (dh % 2 == 0) begin
                    e.row = m; e.scan = sc;
                end else begin
                    e.row  = ((dh >= 2) ? 12 : 0) + m / 2;
                    e.scan = ((m % 2) * 10 + sc) / 2;
                end
            end
        end
        return e;
    endfunction

    string names[8] = '{"h_count", "v_count", "field_o", "sync_o",
                        "text_active", "char_col", "char_row", "cell_line"};
    string tags[8];
    int bad[8], fa[8], fe[8], ft[8];

    task automatic check1(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic compare(int n, int mode, int sf, int dh, int fl);
        exp_t e;
        int a[8], x[8];
        e = model(n, mode, sf, dh, fl);
        a = '{int'(h_count), int'(v_count), int'(field_o), int'(sync_o),
              int'(text_active), int'(char_col), int'(char_row), int'(cell_line)};
        x = '{e.h, e.v, e.fld, e.sync, e.act, e.col, e.row, e.scan};
        for (int i = 0; i < 8; i++) begin
            if (a[i] != x[i]) begin
                if (bad[i] == 0) begin fa[i] = a[i]; fe[i] = x[i]; ft[i] = n; end
                bad[i]++;
            end
        end
    endtask

    task automatic apply_reset(int mode, int sf, int dh, int fl);
        @(negedge clk);
        rst_n = 1'b0; tick_en = 1'b0;
        field_mode = 2'(mode); status_first = 1'(sf); dh_mode = 2'(dh); oe_force_low = 1'(fl);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    // Runs ncyc clocks; with gap > 0 every gap-th clock has tick_en low.
    task automatic run_seq(string label, int mode, int sf, int dh, int fl, int ncyc, int gap);
        int n;
        bit en;
        for (int i = 0; i < 8; i++) begin bad[i] = 0; fa[i] = 0; fe[i] = 0; ft[i] = 0; end
        apply_reset(mode, sf, dh, fl);
        n = 0;
        compare(n, mode, sf, dh, fl);
        for (int c = 0; c < ncyc; c++) begin
            en = (gap == 0) || (c % gap != 0);
            tick_en = en;
            @(negedge clk);
            #1;
            if (en) n++;
            compare(n, mode, sf, dh, fl);
        end
        tick_en = 1'b0;
        for (int i = 0; i < 8; i++) begin
            checks++;
            if (bad[i] != 0) begin
                failures++;
                $display("FAIL %s %s %s: %0d mismatches, first at tick %0d actual=%0d expected=%0d",
                         tags[i], label, names[i], bad[i], ft[i], fa[i], fe[i]);
            end
        end
    endtask

    task automatic set_tags(string tf, string ts, string tr);
        tags = '{"R1", "R2", tf, ts, "R7", "R8", tr, tr};
    endtask

    // R12: reset values
    task automatic test_reset();
        @(negedge clk);
        rst_n = 1'b0; tick_en = 1'b1;
        repeat (4) @(negedge clk);
        check1("R12", "h_count in reset", int'(h_count), 0);
        check1("R12", "v_count in reset", int'(v_count), 1);
        check1("R12", "field_o in reset", int'(field_o), 0);
        check1("R12", "sync_o in reset", int'(sync_o), 0);
        check1("R12", "text_active in reset", int'(text_active), 0);
        tick_en = 1'b0;
    endtask

    // R3 R5 R8 R9 R11: full interlaced frame, status row last
    task automatic test_interlace_frame();
        set_tags("R3", "R5", "R8");
        run_seq("interlace", 0, 0, 0, 0, 625 * 64 + 200, 0);
    endtask

    // R4: alternating fields with odd/even forced low
    task automatic test_alternate_forced();
        set_tags("R4", "R5", "R11");
        run_seq("alternate_forced", 1, 0, 0, 1, 625 * 64 + 200, 0);
    endtask

    // R9: fixed 312-line fields, status row first
    task automatic test_fixed_status_first();
        set_tags("R3", "R5", "R9");
        run_seq("fixed_status_first", 2, 1, 0, 0, 624 * 64 + 200, 0);
    endtask

    // R6: external sync keeps sync_o low
    task automatic test_external();
        set_tags("R4", "R6", "R8");
        run_seq("external", 3, 0, 0, 0, 2000, 0);
    endtask

    // R10: upper half stretched, status last
    task automatic test_dh_upper();
        set_tags("R4", "R5", "R10");
        run_seq("dh_upper", 0, 0, 1, 0, 300 * 64, 0);
    endtask

    // R10 with R9: lower half stretched, status first
    task automatic test_dh_lower_status_first();
        set_tags("R4", "R5", "R10");
        run_seq("dh_lower_status_first", 1, 1, 3, 0, 300 * 64, 0);
    endtask

    // R1: counters hold while tick_en is low
    task automatic test_tick_gating();
        set_tags("R4", "R5", "R8");
        run_seq("tick_gating", 0, 0, 0, 0, 3000, 3);
    endtask

    initial begin
        test_reset();
        test_interlace_frame();
        test_alternate_forced();
        test_fixed_status_first();
        test_external();
        test_dh_upper();
        test_dh_lower_status_first();
        test_tick_gating();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule